// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block is the command state machine of a small NOR-style parallel flash model. It watches host write cycles on an address/data bus and recognises multi-cycle command sequences. Each sequence opens with a pair of unlock writes. It supports four things: a program operation, a query mode that reports which sectors are write-protected, a shortened-program mode that skips the unlock pair, and a return to plain array reads.

A program request starts a timed embedded operation. For its whole duration the ready output is low, every read returns a status byte instead of array contents, and host writes are discarded. The storage is a small register array that starts fully erased. Programming can only clear bits. A byte/word mode input selects the access width. In byte mode it also moves the protect-query offset to the doubled byte address.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, ready is 1, the block is in array read mode and every word reads FFFFh.
- R2: A program takes four writes: AAh at address 555h, 55h at address 2AAh, a setup write with data A0h at any address, and then the target address with its data. Only the low 8 data bits of the first three writes are compared.
- R3: The query mode is entered with AAh@555h, 55h@2AAh and then 90h. In word mode, a read at word offset 2 inside a sector returns 0002h if that sector's protect_mask bit is 1, and 0000h otherwise. Every other address returns 0000h. A sector is numbered by the top SECT_W bits of the word index.
- R4: The query mode survives any number of reads and any write whose low byte is not F0h. A write of F0h returns the block to array reads.
- R5: In byte mode, address bit 0 selects the byte lane (1 = high byte) and the word index is the address shifted right by one. A read returns the selected byte zero-extended. The protect query then answers at byte offset 4 of a sector.
- R6: After the data write of a program, ready is low for exactly PROG_CYCLES clock cycles. Writes made while ready is low have no effect.
- R7: While ready is low, a read at any address returns a status word. Bit 7 is the complement of bit 7 of the data being programmed. Bit 6 inverts after each read strobe. All other bits are 0.
- R8: A program stores the previous word ANDed with the new data, so it can only clear bits.
- R9: A byte-mode program changes only the addressed byte lane.
- R10: A wrong address or data value in either unlock write, or an unknown command byte after the unlock pair, drops the sequence and returns to array reads. No program starts.
- R11: AAh@555h, 55h@2AAh and then 20h enter bypass mode. In bypass mode a program is A0h followed by the address/data write, and after completion the block is back in bypass mode. Reads return array data. Writes other than A0h and 90h, including F0h, are ignored.
- R12: In bypass mode, 90h followed by 00h at any addresses returns the block to normal array reads. 90h followed by any other value stays in bypass mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 selects byte access, 0 word access |
| we | input | 1 | Write strobe, one cycle per bus write |
| re | input | 1 | Read strobe, advances the status toggle bit |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Write data |
| prot_mask | input | 2**SECT_W | Per-sector protect flags |
| rdata | output | DATA_W | Read data: array word/byte, query answer or status |
| ready | output | 1 | 1 when no program is in progress |

## Verification
On every clock, assertions check four things: the busy countdown cannot end early, and the query and bypass modes hold across every write that must not leave them. They also check that the status toggle flips on each read strobe while busy and that no stored bit ever goes from 0 to 1. Whether whole sequences decode correctly can only be shown by the bench's scenarios. These include aborted unlocks, writes discarded while busy, and bypass exit. The bench also sweeps the protect answers across all masks and offsets in both widths, and checks that programming lands in the right word and byte lane.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
   typedef enum logic [3:0] {
      ST_READ, ST_UNL1, ST_UNL2, ST_PGM, ST_ASEL,
      ST_BYP, ST_BYP_PGM, ST_BYP_EXIT, ST_BUSY
   } fcd_state_e;

   localparam logic [7:0]  CMD_KEY_A   = 8'hAA;
   localparam logic [7:0]  CMD_KEY_B   = 8'h55;
   localparam logic [7:0]  CMD_PGM     = 8'hA0;
   localparam logic [7:0]  CMD_QUERY   = 8'h90;
   localparam logic [7:0]  CMD_BYPASS  = 8'h20;
   localparam logic [7:0]  CMD_RST     = 8'hF0;
   localparam logic [7:0]  CMD_LEAVE   = 8'h00;
   localparam logic [11:0] KEY_ADDR_A  = 12'h555;
   localparam logic [11:0] KEY_ADDR_B  = 12'h2AA;
endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
   import fcd_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 16,
   parameter int PA_W        = 5,
   parameter int PROG_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output fcd_state_e        state,
   output logic              busy,
   output logic              commit,
   output logic [PA_W-1:0]   pa,
   output logic [DATA_W-1:0] pd
);
   localparam int CNT_W = $clog2(PROG_CYCLES + 1);

   fcd_state_e       nxt;
   logic [CNT_W-1:0] cnt;
   logic             ret_byp;
   logic [7:0]       d8;
   logic [11:0]      a12;

   assign d8  = wdata[7:0];
   assign a12 = addr[11:0];

   always_comb begin
      nxt = state;
      case (state)
         ST_READ:     nxt = (d8 == CMD_KEY_A && a12 == KEY_ADDR_A) ? ST_UNL1 : ST_READ;
         ST_UNL1:     nxt = (d8 == CMD_KEY_B && a12 == KEY_ADDR_B) ? ST_UNL2 : ST_READ;
         ST_UNL2: begin
            case (d8)
               CMD_PGM:    nxt = ST_PGM;
               CMD_QUERY:  nxt = ST_ASEL;
               CMD_BYPASS: nxt = ST_BYP;
               default:    nxt = ST_READ;
            endcase
         end
         ST_PGM:      nxt = ST_BUSY;
         ST_ASEL:     nxt = (d8 == CMD_RST) ? ST_READ : ST_ASEL;
         ST_BYP:      nxt = (d8 == CMD_PGM) ? ST_BYP_PGM :
                            (d8 == CMD_QUERY) ? ST_BYP_EXIT : ST_BYP;
         ST_BYP_PGM:  nxt = ST_BUSY;
         ST_BYP_EXIT: nxt = (d8 == CMD_LEAVE) ? ST_READ : ST_BYP;
         default:     nxt = state;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_READ;
         cnt     <= '0;
         ret_byp <= 1'b0;
         pa      <= '0;
         pd      <= '0;
      end else if (state == ST_BUSY) begin
         if (cnt == '0) begin
            state <= ret_byp ? ST_BYP : ST_READ;
            pa    <= '0;
            pd    <= '0;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end else if (we) begin
         state <= nxt;
         if (state == ST_PGM || state == ST_BYP_PGM) begin
            pa      <= addr[PA_W-1:0];
            pd      <= wdata;
            cnt     <= CNT_W'(PROG_CYCLES - 1);
            ret_byp <= (state == ST_BYP_PGM);
         end
      end
   end

   assign busy   = (state == ST_BUSY);
   assign commit = busy && (cnt == '0);

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BUSY && cnt != '0) |=> (state == ST_BUSY)); // R6
   AST_QUERY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ASEL && !(we && d8 == CMD_RST)) |=> (state == ST_ASEL)); // R4
   AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BYP && (!we || (d8 != CMD_PGM && d8 != CMD_QUERY))) |=> (state == ST_BYP)); // R11
endmodule

// File: rtl/fcd_array.sv
module fcd_array #(
   parameter int ARR_AW = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic              byte_mode,
   input  logic [ARR_AW-1:0] wr_idx,
   input  logic              wr_lane,
   input  logic [DATA_W-1:0] pd,
   input  logic [ARR_AW-1:0] rd_idx,
   output logic [DATA_W-1:0] rd_word
);
   localparam int DEPTH = 1 << ARR_AW;
   localparam int HALF  = DATA_W / 2;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] clr_mask;

   generate
      if (DATA_W == 2 * HALF) begin : g_lanes
         always_comb begin
            if (!byte_mode)
               clr_mask = pd;
            else if (wr_lane)
               clr_mask = {pd[HALF-1:0], {HALF{1'b1}}};
            else
               clr_mask = {{HALF{1'b1}}, pd[HALF-1:0]};
         end
      end else begin : g_word_only
         assign clr_mask = pd;
      end
   endgenerate

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (!rst_n)
            mem[i] <= '1;
         else if (commit && wr_idx == ARR_AW'(i))
            mem[i] <= mem[i] & clr_mask;
      end
   end

   assign rd_word = mem[rd_idx];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_chk
         AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (mem[g] & ~$past(mem[g])) == '0); // R8
      end
   endgenerate
endmodule

// File: rtl/fcd_rdmux.sv
module fcd_rdmux
   import fcd_pkg::*;
#(
   parameter int ARR_AW = 4,
   parameter int SECT_W = 2,
   parameter int DATA_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  fcd_state_e             state,
   input  logic                   re,
   input  logic                   byte_mode,
   input  logic                   lane,
   input  logic [ARR_AW-1:0]      rd_idx,
   input  logic [DATA_W-1:0]      rd_word,
   input  logic                   pgm_bit7,
   input  logic [(1<<SECT_W)-1:0] prot_mask,
   output logic [DATA_W-1:0]      rdata
);
   localparam int OFF_W = ARR_AW - SECT_W;
   localparam int HALF  = DATA_W / 2;

   logic              tog;
   logic              busy;
   logic              hit;
   logic [SECT_W-1:0] sect;
   logic [OFF_W-1:0]  off;

   assign busy = (state == ST_BUSY);
   assign sect = rd_idx[ARR_AW-1 -: SECT_W];
   assign off  = rd_idx[OFF_W-1:0];
   assign hit  = (off == OFF_W'(2)) && (!byte_mode || !lane);

   always_ff @(posedge clk) begin
      if (!rst_n)    tog <= 1'b0;
      else if (!busy) tog <= 1'b0;
      else if (re)   tog <= ~tog;
   end

   always_comb begin
      rdata = '0;
      if (busy) begin
         rdata[7] = ~pgm_bit7;
         rdata[6] = tog;
      end else if (state == ST_ASEL) begin
         rdata[1] = hit && prot_mask[sect];
      end else if (byte_mode) begin
         rdata[HALF-1:0] = lane ? rd_word[DATA_W-1:HALF] : rd_word[HALF-1:0];
      end else begin
         rdata = rd_word;
      end
   end

   AST_STATUS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && re) |=> (!busy || tog != $past(tog))); // R7
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 16,
   parameter int ARR_AW      = 4,
   parameter int SECT_W      = 2,
   parameter int PROG_CYCLES = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   byte_mode,
   input  logic                   we,
   input  logic                   re,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      wdata,
   input  logic [(1<<SECT_W)-1:0] prot_mask,
   output logic [DATA_W-1:0]      rdata,
   output logic                   ready
);
   localparam int PA_W = ARR_AW + 1;

   generate
      if (DATA_W != 16)            begin : g_bad_dw  $error("DATA_W must be 16"); end
      if (ADDR_W < 12)             begin : g_bad_aw  $error("ADDR_W must be at least 12"); end
      if (ADDR_W <= ARR_AW)        begin : g_bad_arr $error("ARR_AW must be below ADDR_W"); end
      if (ARR_AW - SECT_W < 2)     begin : g_bad_off $error("sectors need at least 4 words"); end
      if (PROG_CYCLES < 1)         begin : g_bad_pc  $error("PROG_CYCLES must be positive"); end
   endgenerate

   fcd_state_e        state;
   logic              busy;
   logic              commit;
   logic [PA_W-1:0]   pa;
   logic [DATA_W-1:0] pd;
   logic [ARR_AW-1:0] rd_idx;
   logic [ARR_AW-1:0] wr_idx;
   logic [DATA_W-1:0] rd_word;

   assign rd_idx = byte_mode ? addr[ARR_AW:1] : addr[ARR_AW-1:0];
   assign wr_idx = byte_mode ? pa[ARR_AW:1]   : pa[ARR_AW-1:0];
   assign ready  = !busy;

   fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PA_W(PA_W), .PROG_CYCLES(PROG_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
      .state(state), .busy(busy), .commit(commit), .pa(pa), .pd(pd)
   );

   fcd_array #(.ARR_AW(ARR_AW), .DATA_W(DATA_W)) u_array (
      .clk(clk), .rst_n(rst_n), .commit(commit), .byte_mode(byte_mode),
      .wr_idx(wr_idx), .wr_lane(pa[0]), .pd(pd), .rd_idx(rd_idx), .rd_word(rd_word)
   );

   fcd_rdmux #(.ARR_AW(ARR_AW), .SECT_W(SECT_W), .DATA_W(DATA_W)) u_rdmux (
      .clk(clk), .rst_n(rst_n), .state(state), .re(re), .byte_mode(byte_mode),
      .lane(addr[0]), .rd_idx(rd_idx), .rd_word(rd_word), .pgm_bit7(pd[7]),
      .prot_mask(prot_mask), .rdata(rdata)
   );
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
   localparam int P = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_mode = 1'b0;
   logic        we = 1'b0;
   logic        re = 1'b0;
   logic [11:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [3:0]  prot_mask = '0;
   logic [15:0] rdata;
   logic        ready;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [15:0] mdl [16];

   always #2 clk = ~clk;

   flash_cmd_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .we(we), .re(re),
      .addr(addr), .wdata(wdata), .prot_mask(prot_mask), .rdata(rdata), .ready(ready)
   );

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1'b1;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [15:0] exp, input string req);
      @(negedge clk); addr = a; #1;
      chk(rdata === exp, req, rdata, exp);
   endtask

   task automatic unlock(input logic [7:0] cmd);
      wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, {8'h00, cmd});
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (ready !== 1'b1 && n < 1000) begin n++; @(negedge clk); end
   endtask

   task automatic model_pgm(input logic [11:0] a, input logic [15:0] d, input bit bm);
      if (!bm) mdl[a[3:0]] = mdl[a[3:0]] & d;
      else if (a[0]) mdl[a[4:1]] = mdl[a[4:1]] & {d[7:0], 8'hFF};
      else mdl[a[4:1]] = mdl[a[4:1]] & {8'hFF, d[7:0]};
   endtask

   task automatic check_all(input string req);
      for (int w = 0; w < 16; w++) rd(12'(w), mdl[w], req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int n;
      for (int i = 0; i < 16; i++) mdl[i] = 16'hFFFF;
      repeat (3) @(negedge clk);
      #1; chk(ready === 1'b1, "R1 ready after reset", {15'h0, ready}, 16'h1);
      rst_n = 1'b1;
      check_all("R1 erased array");

      // R6 busy length and R2 four-cycle program
      unlock(8'hA0); wr(12'h003, 16'h1234); model_pgm(12'h003, 16'h1234, 1'b0);
      wait_ready(n);
      chk(n == P, "R6 busy cycle count", 16'(n), 16'(P));
      rd(12'h003, mdl[3], "R2 programmed word");

      // R7 status during busy
      unlock(8'hA0); wr(12'h007, 16'h0F7F); model_pgm(12'h007, 16'h0F7F, 1'b0);
      #1; chk(rdata === 16'h0080, "R7 status bit7 and toggle start", rdata, 16'h0080);
      re = 1'b1; @(negedge clk); re = 1'b0; addr = 12'h00C; #1;
      chk(rdata === 16'h00C0, "R7 toggle after first read", rdata, 16'h00C0);
      re = 1'b1; @(negedge clk); re = 1'b0; #1;
      chk(rdata === 16'h0080, "R7 toggle after second read", rdata, 16'h0080);
      // R6 writes during busy ignored
      wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h00A0); wr(12'h00B, 16'h0000);
      wait_ready(n);
      check_all("R6 busy writes ignored");

      // R2 R8 sweep over all words, two passes
      for (int w = 0; w < 16; w++) begin
         logic [15:0] d;
         d = 16'hF3CF ^ 16'(w * 16'h1111);
         unlock(8'hA0); wr(12'(w), d); model_pgm(12'(w), d, 1'b0); wait_ready(n);
      end
      check_all("R2 sweep first pass");
      for (int w = 0; w < 16; w++) begin
         logic [15:0] d;
         d = ~16'(w * 16'h0909);
         unlock(8'hA0); wr(12'(w), d); model_pgm(12'(w), d, 1'b0); wait_ready(n);
      end
      check_all("R8 AND on reprogram");

      // R3 R4 query sweep, word mode
      for (int m = 0; m < 16; m++) begin
         prot_mask = 4'(m);
         unlock(8'h90);
         for (int w = 0; w < 16; w++)
            rd(12'(w), ((w % 4) == 2 && m[w / 4]) ? 16'h0002 : 16'h0000, "R3 protect query word");
         wr(12'h555, 16'h00AA); wr(12'h00A, 16'h0000);
         rd(12'h00A, m[2] ? 16'h0002 : 16'h0000, "R4 query persists");
         wr(12'h000, 16'h00F0);
         rd(12'h00A, mdl[10], "R4 reset leaves query");
      end

      // R5 byte-mode query and reads
      byte_mode = 1'b1; prot_mask = 4'b1010;
      unlock(8'h90);
      for (int b = 0; b < 32; b++)
         rd(12'(b), ((b % 8) == 4 && prot_mask[b / 8]) ? 16'h0002 : 16'h0000, "R5 protect query byte");
      wr(12'h000, 16'h00F0);
      for (int b = 0; b < 32; b++)
         rd(12'(b), {8'h00, (b % 2 == 1) ? mdl[b / 2][15:8] : mdl[b / 2][7:0]}, "R5 byte read lane");

      // R9 byte program per lane
      for (int b = 0; b < 32; b += 3) begin
         logic [7:0] d;
         d = 8'h5A ^ 8'(b * 8'h13);
         unlock(8'hA0); wr(12'(b), {8'h00, d}); model_pgm(12'(b), {8'h00, d}, 1'b1); wait_ready(n);
      end
      byte_mode = 1'b0;
      check_all("R9 byte program lanes");

      // R10 aborted sequences
      for (int w = 0; w < 16; w++) mdl[w] = mdl[w];
      wr(12'h555, 16'h00AA); wr(12'h2AB, 16'h0055); wr(12'h555, 16'h00A0); wr(12'h001, 16'h0000);
      wr(12'h555, 16'h00AB); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h00A0); wr(12'h002, 16'h0000);
      wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0054); wr(12'h555, 16'h00A0); wr(12'h004, 16'h0000);
      unlock(8'h77); wr(12'h555, 16'h00A0); wr(12'h005, 16'h0000);
      wr(12'h555, 16'h00AA); wr(12'h000, 16'h00F0); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h00A0); wr(12'h006, 16'h0000);
      #1; chk(ready === 1'b1, "R10 no program after abort", {15'h0, ready}, 16'h1);
      check_all("R10 array unchanged after aborts");

      // R11 bypass mode
      unlock(8'h20);
      rd(12'h009, mdl[9], "R11 bypass reads array");
      wr(12'h008, 16'h00A0); wr(12'h008, 16'hAAF0); model_pgm(12'h008, 16'hAAF0, 1'b0); wait_ready(n);
      chk(n == P, "R11 bypass program busy", 16'(n), 16'(P));
      wr(12'h000, 16'h00F0); wr(12'h123, 16'h0033);
      wr(12'h00D, 16'h00A0); wr(12'h00D, 16'h0F0F); model_pgm(12'h00D, 16'h0F0F, 1'b0); wait_ready(n);
      check_all("R11 bypass kept after program and F0");
      // R12 exit attempts
      wr(12'h3FF, 16'h0090); wr(12'h3FF, 16'h0011);
      wr(12'h00E, 16'h00A0); wr(12'h00E, 16'h3C3C); model_pgm(12'h00E, 16'h3C3C, 1'b0); wait_ready(n);
      check_all("R12 bad exit stays bypass");
      wr(12'h7AB, 16'h0090); wr(12'h001, 16'h0000);
      wr(12'h00F, 16'h00A0); wr(12'h00F, 16'h0000);
      #1; chk(ready === 1'b1, "R12 exit returns to read mode", {15'h0, ready}, 16'h1);
      check_all("R12 no program after exit");
      unlock(8'hA0); wr(12'h00F, 16'h7FFF); model_pgm(12'h00F, 16'h7FFF, 1'b0); wait_ready(n);
      rd(12'h00F, mdl[15], "R12 normal program after exit");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule